// File: doc/BRIEF.md
# Prefetchable 64-bit Memory Base Address Register Pair

This block holds a pair of adjacent configuration dwords that together advertise and decode one fixed-size, prefetchable memory window that may sit anywhere in a 64-bit address space. The size of the window is fixed at build time as a power of two, given by the parameter `SIZE_LOG2`. The low-order bits that fall inside the window are hard-wired. Enumeration software writes all ones to both dwords and reads them back. The bits that stayed at zero show the window size, and the low nibble shows that the request is for 64-bit prefetchable memory.

After software has placed the window, the block compares each incoming 64-bit memory address with the stored base. It raises a hit when the address falls inside the window and memory decoding is enabled. Configuration accesses use a one-bit dword select, four byte enables, a write strobe and a read-data bus that always shows the selected dword.

Top module: `pf_bar64`

## Requirements
- R1: After reset, every writable bit of both dwords is zero, so the lower dword reads 0000000Ch and the upper dword reads 00000000h.
- R2: In the lower dword, bit 0 always reads 0 (memory space), bits 2:1 read 10b (64-bit decode), bit 3 reads 1 (prefetchable), and bits SIZE_LOG2-1 down to 4 (capped at bit 31) read 0. Writes never change these bits.
- R3: Writing FFFFFFFFh to the lower dword with all byte enables set makes it read back with exactly the low SIZE_LOG2 bits unchanged. With SIZE_LOG2=26 it reads FC00000Ch.
- R4: When SIZE_LOG2 is 32 or less, all 32 bits of the upper dword are read-write and hold address bits 63:32 of the base.
- R5: On a write, byte enable k (k = 0..3) updates only bits 8k+7:8k, and only their writable bits. A write with no byte enable set changes nothing.
- R6: The hit output is high when address bits 63 down to SIZE_LOG2 equal the same bits of the stored base and the memory-enable input is high. Otherwise it is low.
- R7: While the memory-enable input is low, the hit output stays low for every address.
- R8: With SIZE_LOG2=26 and base 2_4000_0000h, addresses 2_4000_0000h and 2_43FF_FFFFh hit, while 2_3FFF_FFFFh and 2_4400_0000h miss.
- R9: A dword select of 0 addresses the lower dword (address bits 31:0) and 1 addresses the upper dword (address bits 63:32). Reads are combinational, and a write to one dword leaves the other unchanged.
- R10: When SIZE_LOG2 exceeds 32, the lower dword always reads 0000000Ch. Upper-dword bits SIZE_LOG2-33 down to 0 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Dword select: 0 lower, 1 upper |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| mem_en | input | 1 | Memory decode enable |
| req_addr | input | 64 | Incoming memory address |
| hit | output | 1 | Address falls inside the window |

## Verification
The bench builds two instances from the same stimulus. One uses SIZE_LOG2=26, a 64 MB window whose boundary falls inside the lower dword. The other uses SIZE_LOG2=36, which fixes the whole lower dword and the low nibble of the upper dword. The first instance exercises size discovery, the exact edges of a window placed above 4 GB, and byte-lane writes. The second reaches the case where the size mask crosses into the upper half.

// File: rtl/pf_bar64_pkg.sv
package pf_bar64_pkg;

    // memory space, 64-bit decode, prefetchable
    localparam logic [3:0] BAR_TYPE_CODE = 4'b1100;

    typedef struct packed {
        logic [31:0] val;
    } dword_st_t;

    function automatic logic [63:0] window_mask(input int size_log2);
        return ~((64'd1 << size_log2) - 64'd1);
    endfunction

endpackage

// File: rtl/pf_bar64_dword.sv
module pf_bar64_dword
    import pf_bar64_pkg::*;
#(
    parameter logic [31:0] WR_MASK   = 32'hFFFF_FFFF,
    parameter logic [31:0] FIXED_VAL = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val
);

    localparam int LANES = 4;

    dword_st_t   st_d, st_q;
    logic [31:0] lane_mask;
    logic [31:0] upd_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{be[i]}};
    end

    assign upd_mask = lane_mask & WR_MASK;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = (st_q.val & ~upd_mask) | (wdata & upd_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_val = (st_q.val & WR_MASK) | (FIXED_VAL & ~WR_MASK);

endmodule

// File: rtl/pf_bar64_hit.sv
module pf_bar64_hit #(
    parameter logic [63:0] ADDR_MASK = 64'hFFFF_FFFF_FC00_0000
) (
    input  logic [63:0] req_addr,
    input  logic [63:0] base,
    input  logic        mem_en,
    output logic        hit
);

    logic match;

    assign match = ((req_addr & ADDR_MASK) == (base & ADDR_MASK));
    assign hit   = mem_en && match;

endmodule

// File: rtl/pf_bar64.sv
module pf_bar64
    import pf_bar64_pkg::*;
#(
    parameter int SIZE_LOG2 = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic        cfg_sel,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_en,
    input  logic [63:0] req_addr,
    output logic        hit
);

    localparam logic [63:0] ADDR_MASK = window_mask(SIZE_LOG2);
    localparam logic [31:0] LO_WR     = ADDR_MASK[31:0];
    localparam logic [31:0] HI_WR     = ADDR_MASK[63:32];
    localparam logic [31:0] LO_FIXED  = {28'h0, BAR_TYPE_CODE};

    logic [31:0] dw_val [2];
    logic [31:0] lo_val;
    logic [31:0] hi_val;

    for (genvar g = 0; g < 2; g++) begin : g_dw
        pf_bar64_dword #(
            .WR_MASK   ((g == 0) ? LO_WR : HI_WR),
            .FIXED_VAL ((g == 0) ? LO_FIXED : 32'h0)
        ) dw_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_wr_en && (cfg_sel == g[0])),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .rd_val (dw_val[g])
        );
    end

    assign lo_val    = dw_val[0];
    assign hi_val    = dw_val[1];
    assign cfg_rdata = cfg_sel ? hi_val : lo_val;

    pf_bar64_hit #(
        .ADDR_MASK (ADDR_MASK)
    ) hit_i (
        .req_addr (req_addr),
        .base     ({hi_val, lo_val}),
        .mem_en   (mem_en),
        .hit      (hit)
    );

endmodule

// File: rtl/pf_bar64_chk.sv
module pf_bar64_chk
    import pf_bar64_pkg::*;
#(
    parameter int SIZE_LOG2 = 26
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic        cfg_sel,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        mem_en,
    input logic        hit,
    input logic [31:0] lo_val,
    input logic [31:0] hi_val
);

    localparam logic [63:0] AMASK = window_mask(SIZE_LOG2);
    localparam logic [31:0] LO_FIX_MASK = ~AMASK[31:0];
    localparam logic [31:0] HI_WR = AMASK[63:32];

    // R2 / R10: fixed low bits of the lower dword
    always_comb begin
        if (rst_n === 1'b1) begin
            p_fixed_bits_r2: assert ((lo_val & LO_FIX_MASK) == {28'h0, BAR_TYPE_CODE});
        end
    end

    // R7
    p_no_hit_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> !hit);

    // R5
    p_no_be_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_sel && cfg_be == 4'h0) |=> $stable(lo_val));

    // R4 / R10
    p_hi_full_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_sel && cfg_be == 4'hF) |=> hi_val == ($past(cfg_wdata) & HI_WR));

    // R9
    p_sel_isolation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_sel) |=> $stable(lo_val));

    // R9
    p_read_mux_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> cfg_rdata == hi_val);

endmodule

bind pf_bar64 pf_bar64_chk #(.SIZE_LOG2(SIZE_LOG2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_sel   (cfg_sel),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mem_en    (mem_en),
    .hit       (hit),
    .lo_val    (lo_val),
    .hi_val    (hi_val)
);

// File: tb/pf_bar64_tb_top.sv
module pf_bar64_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_en = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] rdata26, rdata36;
    logic        hit26, hit36;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_bar64 #(.SIZE_LOG2(26)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata26),
        .mem_en(mem_en), .req_addr(req_addr), .hit(hit26)
    );

    pf_bar64 #(.SIZE_LOG2(36)) dut36_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata36),
        .mem_en(mem_en), .req_addr(req_addr), .hit(hit36)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_be = be; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic read_both(input logic sel, output logic [31:0] r26, output logic [31:0] r36);
        cfg_sel = sel;
        #1;
        r26 = rdata26;
        r36 = rdata36;
    endtask

    task automatic probe(input logic [63:0] a, input logic en, output logic h26, output logic h36);
        req_addr = a; mem_en = en;
        #1;
        h26 = hit26;
        h36 = hit36;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        read_both(1'b0, a, b);
        check("R1 lower after reset", a, 32'h0000_000C);
        check("R10 lower after reset s36", b, 32'h0000_000C);
        read_both(1'b1, a, b);
        check("R1 upper after reset", a, 32'h0);
        check("R1 upper after reset s36", b, 32'h0);
    endtask

    task automatic t_size_discovery();
        logic [31:0] a, b;
        cfg_write(1'b0, 4'hF, 32'hFFFF_FFFF);
        cfg_write(1'b1, 4'hF, 32'hFFFF_FFFF);
        read_both(1'b0, a, b);
        check("R3 lower all-ones readback", a, 32'hFC00_000C);
        check("R10 lower all-ones readback s36", b, 32'h0000_000C);
        read_both(1'b1, a, b);
        check("R4 upper all-ones readback", a, 32'hFFFF_FFFF);
        check("R10 upper all-ones readback s36", b, 32'hFFFF_FFF0);
    endtask

    task automatic t_fixed_bits();
        logic [31:0] a, b;
        cfg_write(1'b0, 4'hF, 32'h0000_003F);
        read_both(1'b0, a, b);
        check("R2 fixed low bits ignore write", a, 32'h0000_000C);
        check("R2 fixed low bits ignore write s36", b, 32'h0000_000C);
    endtask

    task automatic t_byte_enables();
        logic [31:0] a, b;
        cfg_write(1'b1, 4'hF, 32'h1234_5678);
        read_both(1'b1, a, b);
        check("R4 upper full write", a, 32'h1234_5678);
        cfg_write(1'b1, 4'b0101, 32'hAABB_CCDD);
        read_both(1'b1, a, b);
        check("R5 byte lanes 0 and 2", a, 32'h12BB_56DD);
        check("R5 byte lanes s36", b, 32'h12BB_56D0);
        cfg_write(1'b1, 4'h0, 32'hFFFF_FFFF);
        read_both(1'b1, a, b);
        check("R5 no byte enable", a, 32'h12BB_56DD);
        cfg_write(1'b0, 4'b1000, 32'hA5FF_FFFF);
        read_both(1'b0, a, b);
        check("R5 lower top lane only", a, 32'hA400_000C);
        read_both(1'b1, a, b);
        check("R9 lower write leaves upper", a, 32'h12BB_56DD);
    endtask

    task automatic t_decode();
        logic [31:0] a, b;
        logic h26, h36;
        cfg_write(1'b1, 4'hF, 32'h0000_0002);
        cfg_write(1'b0, 4'hF, 32'h4000_0000);
        read_both(1'b0, a, b);
        check("R9 select lower", a, 32'h4000_000C);
        read_both(1'b1, a, b);
        check("R9 select upper", a, 32'h0000_0002);
        probe(64'h2_4000_0000, 1'b1, h26, h36);
        check("R8 first byte hits", h26, 1'b1);
        check("R10 window s36 hit", h36, 1'b1);
        probe(64'h2_43FF_FFFF, 1'b1, h26, h36);
        check("R8 last byte hits", h26, 1'b1);
        probe(64'h2_3FFF_FFFF, 1'b1, h26, h36);
        check("R8 below window misses", h26, 1'b0);
        probe(64'h2_4400_0000, 1'b1, h26, h36);
        check("R8 above window misses", h26, 1'b0);
        probe(64'h3_4000_0000, 1'b1, h26, h36);
        check("R6 upper bits differ misses", h26, 1'b0);
        probe(64'h2_4123_4567, 1'b1, h26, h36);
        check("R6 inside window hits", h26, 1'b1);
        probe(64'h10_0000_0000, 1'b1, h26, h36);
        check("R10 outside s36 window", h36, 1'b0);
        probe(64'h2_4000_0000, 1'b0, h26, h36);
        check("R7 disabled no hit", h26, 1'b0);
        check("R7 disabled no hit s36", h36, 1'b0);
        mem_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_size_discovery();
        t_fixed_bits();
        t_byte_enables();
        t_decode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule